// File: doc/BRIEF.md
# I2C Register Access Engine

This block sits behind a byte-level I2C target front end. The front end reports events: an address byte with its direction, each received data byte, each request for a byte to transmit, and the stop condition. The engine returns one acknowledge decision per address or data byte and one data byte per read request. Each response appears in the clock cycle after the event. The register file holds control, measurement-rate, gain, identity, status, four 20-bit light-sensor result channels, interrupt configuration, persistence and a pair of 20-bit thresholds plus a variance code, all at fixed addresses.

The first byte after a write-direction address sets the register pointer. Later bytes in the same transfer write registers, and the pointer steps forward only through addresses that can be written. A read-direction transfer returns bytes from the pointer and steps through every populated address. The pointer never wraps past the top of the map. While a read is positioned on the status or result addresses, fresh conversion results wait in a shadow copy. The visible result bytes of one read therefore always come from a single conversion.

Top module: `i2c_reg_engine`

## Requirements
- R1: An address event is acknowledged only when `bootDone` is high and the 7-bit address equals 0x52. Otherwise it is refused, and every data byte of that transfer is also refused.
- R2: The first byte after an accepted write-direction address loads the register pointer and is always acknowledged.
- R3: In a block write, the pointer advances from the written address to the next writable address: 0x00, 0x04, 0x05, 0x19, 0x1A, 0x21–0x27. For example, 0x05 is followed by 0x19 and 0x1A by 0x21.
- R4: After 0x27 has been written, the pointer does not wrap. Every further byte of the transfer is refused and changes no register.
- R5: A write whose pointer names a non-writable address is refused for every byte until the transfer ends, and the addressed register keeps its value.
- R6: Unused bits are held at zero. The masks are: control 0x16, rate 0x77, gain 0x07, interrupt config 0x3C, persistence 0xF0, variance 0x07. The top byte of every 20-bit result or threshold keeps bits [3:0] only.
- R7: A block read advances through the populated addresses 0x00, 0x04–0x07, 0x0A–0x15, 0x19–0x1A and 0x21–0x27. After 0x27 it returns 0x00 for every further byte without wrapping.
- R8: A read-direction address is refused when the pointer names an unpopulated address, and every read byte of that transfer is 0x00.
- R9: After reset, the registers read: control 0x00, rate 0x22, gain 0x01, identity 0xB2, status 0x20, interrupt config 0x10, persistence 0x00, upper threshold 0x0FFFFF, lower threshold 0, variance 0, results 0.
- R10: Status bit 5 is the power-on flag, bit 4 the interrupt flag (set by `intSet`) and bit 3 the new-result flag (set when a result becomes visible). Reading status clears all three flags.
- R11: While a read transfer points into 0x07–0x18, a new result is held back. It becomes visible once the transfer stops or the pointer leaves that range.
- R12: `restartPulse` is high for one cycle after each accepted write to 0x00, 0x04 or 0x05, and never after a write to any other address.
- R13: The acknowledge for an address or data byte and the data for a read request are valid in the cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootDone | input | 1 | Start-up load finished; before that every address is refused |
| startEv | input | 1 | Start or repeated start with address byte received |
| addrIn | input | 7 | Target address of the address byte |
| dirRead | input | 1 | Direction bit of the address byte, 1 for read |
| rxValid | input | 1 | Data byte received from the controller |
| rxByte | input | 8 | Received data byte |
| rdReq | input | 1 | Front end needs the next byte to transmit |
| stopEv | input | 1 | Stop condition seen |
| resValid | input | 1 | New conversion result on `resFlat` |
| resFlat | input | 80 | Results, channel c at bits [20c+19:20c]: ir, green, blue, red |
| intSet | input | 1 | Sets the interrupt flag |
| ackValid | output | 1 | `ackOut` is valid this cycle |
| ackOut | output | 1 | 1 acknowledges, 0 refuses |
| rdValid | output | 1 | `rdData` is valid this cycle |
| rdData | output | 8 | Byte to transmit |
| restartPulse | output | 1 | Measurement settings were rewritten |

## Verification
The bench uses the default parameters: a 20-bit result width and target address 0x52. With these values, the partial top byte of results and thresholds can be observed, and a block read runs through the full result range. The whole map is small enough for a bench model to track every address. Runs of block reads and writes are directed at the two map gaps, at the top address and at the locked range. A conversion result is injected mid-read to show the held-back update and its later release.

// File: rtl/rae_pkg.sv
package rae_pkg;

  localparam logic [7:0] TOP_ADDR   = 8'h27;
  localparam logic [7:0] LOCK_LO    = 8'h07;
  localparam logic [7:0] LOCK_HI    = 8'h18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_WRITE,
    ST_READ,
    ST_REJECT
  } xferState_t;

  typedef struct packed {
    logic       wrEn;
    logic [7:0] wrAddr;
    logic [7:0] wrData;
    logic       rdEn;
    logic [7:0] rdAddr;
    logic       rdBlank;
    logic       lockRes;
  } regStrobe_t;

  function automatic logic isPopulated(input logic [7:0] a);
    return (a == 8'h00) || (a >= 8'h04 && a <= 8'h07) ||
           (a >= 8'h0A && a <= 8'h15) || (a == 8'h19) || (a == 8'h1A) ||
           (a >= 8'h21 && a <= TOP_ADDR);
  endfunction

  function automatic logic isWritable(input logic [7:0] a);
    return (a == 8'h00) || (a == 8'h04) || (a == 8'h05) ||
           (a == 8'h19) || (a == 8'h1A) || (a >= 8'h21 && a <= TOP_ADDR);
  endfunction

  function automatic logic inLockRange(input logic [7:0] a);
    return (a >= LOCK_LO) && (a <= LOCK_HI);
  endfunction

  // {found, address}: smallest populated address above a
  function automatic logic [8:0] nextPopulated(input logic [7:0] a);
    logic [8:0] r;
    r = {1'b0, a};
    for (int i = int'(TOP_ADDR); i > 0; i--) begin
      if (i > int'(a) && isPopulated(8'(i))) r = {1'b1, 8'(i)};
    end
    return r;
  endfunction

  function automatic logic [8:0] nextWritable(input logic [7:0] a);
    logic [8:0] r;
    r = {1'b0, a};
    for (int i = int'(TOP_ADDR); i > 0; i--) begin
      if (i > int'(a) && isWritable(8'(i))) r = {1'b1, 8'(i)};
    end
    return r;
  endfunction

endpackage

// File: rtl/rae_ctrl.sv
module rae_ctrl
  import rae_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h52
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bootDone,
  input  logic       startEv,
  input  logic [6:0] addrIn,
  input  logic       dirRead,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       rdReq,
  input  logic       stopEv,
  output logic       ackValid,
  output logic       ackOut,
  output regStrobe_t strobe
);

  xferState_t state, stateNext;
  logic [7:0] ptrQ, ptrNext;
  logic       pastEndQ, pastEndNext;
  logic       ackVNext, ackNext, ptrLoad;
  logic [8:0] stepW, stepR;

  assign stepW = nextWritable(ptrQ);
  assign stepR = nextPopulated(ptrQ);

  always_comb begin
    stateNext   = state;
    ptrNext     = ptrQ;
    pastEndNext = pastEndQ;
    ackVNext    = 1'b0;
    ackNext     = 1'b0;
    ptrLoad     = 1'b0;
    strobe.wrEn    = 1'b0;
    strobe.wrAddr  = ptrQ;
    strobe.wrData  = rxByte;
    strobe.rdEn    = rdReq;
    strobe.rdAddr  = ptrQ;
    strobe.rdBlank = (state != ST_READ) || pastEndQ;
    strobe.lockRes = (state == ST_READ) && inLockRange(ptrQ);

    if (startEv) begin
      ackVNext    = 1'b1;
      pastEndNext = 1'b0;
      if (!bootDone || addrIn != SLAVE_ADDR) begin
        stateNext = ST_REJECT;
      end else if (!dirRead) begin
        stateNext = ST_PTR;
        ackNext   = 1'b1;
      end else if (isPopulated(ptrQ)) begin
        stateNext = ST_READ;
        ackNext   = 1'b1;
      end else begin
        stateNext = ST_REJECT;
      end
    end else if (stopEv) begin
      stateNext   = ST_IDLE;
      pastEndNext = 1'b0;
    end else begin
      if (rxValid) begin
        ackVNext = 1'b1;
        if (state == ST_PTR) begin
          ptrNext   = rxByte;
          ptrLoad   = 1'b1;
          ackNext   = 1'b1;
          stateNext = ST_WRITE;
        end else if (state == ST_WRITE) begin
          if (!pastEndQ && isWritable(ptrQ)) begin
            strobe.wrEn = 1'b1;
            ackNext     = 1'b1;
            if (stepW[8]) ptrNext = stepW[7:0];
            else          pastEndNext = 1'b1;
          end else begin
            pastEndNext = 1'b1;
          end
        end
      end
      if (rdReq && state == ST_READ && !pastEndQ) begin
        if (stepR[8]) ptrNext = stepR[7:0];
        else          pastEndNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ptrQ     <= 8'h00;
      pastEndQ <= 1'b0;
      ackValid <= 1'b0;
      ackOut   <= 1'b0;
    end else begin
      state    <= stateNext;
      ptrQ     <= ptrNext;
      pastEndQ <= pastEndNext;
      ackValid <= ackVNext;
      ackOut   <= ackNext;
    end
  end

  AST_BOOT_NACK: assert property (@(posedge clk) disable iff (!rstN)
    startEv && !bootDone |=> ackValid && !ackOut); // R1
  AST_BYTE_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !startEv && !stopEv |=> ackValid); // R13
  AST_NO_ROLLOVER: assert property (@(posedge clk) disable iff (!rstN)
    !ptrLoad |=> ptrQ >= $past(ptrQ)); // R4

endmodule

// File: rtl/rae_regs.sv
module rae_regs
  import rae_pkg::*;
#(
  parameter int         RES_W    = 20,
  parameter int         NUM_CH   = 4,
  parameter logic [7:0] ID_VALUE = 8'hB2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              strobe,
  input  logic                    resValid,
  input  logic [NUM_CH*RES_W-1:0] resFlat,
  input  logic                    intSet,
  output logic                    rdValid,
  output logic [7:0]              rdData,
  output logic                    restartPulse
);

  localparam int MSB_W = RES_W - 16;
  localparam logic [7:0] DATA_BASE = 8'h0A;

  logic [7:0]       ctrlQ, rateQ, gainQ, icfgQ, persQ, varQ;
  logic [RES_W-1:0] thrUpQ, thrLoQ;
  logic [RES_W-1:0] shadowQ [NUM_CH];
  logic [RES_W-1:0] visQ    [NUM_CH];
  logic             pendQ, flagPow, flagInt, flagNew;
  logic             commit, rdStatus;
  logic [7:0]       readVal;

  assign commit   = pendQ && !strobe.lockRes;
  assign rdStatus = strobe.rdEn && !strobe.rdBlank && strobe.rdAddr == 8'h07;

  function automatic logic [7:0] byteOf(input logic [RES_W-1:0] v, input int idx);
    logic [23:0] p;
    p = 24'(v);
    return p[idx*8 +: 8];
  endfunction

  // settings and thresholds
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= 8'h00;
      rateQ  <= 8'h22;
      gainQ  <= 8'h01;
      icfgQ  <= 8'h10;
      persQ  <= 8'h00;
      varQ   <= 8'h00;
      thrUpQ <= {MSB_W'('1), 16'hFFFF};
      thrLoQ <= '0;
      restartPulse <= 1'b0;
    end else begin
      restartPulse <= 1'b0;
      if (strobe.wrEn) begin
        case (strobe.wrAddr)
          8'h00: begin ctrlQ <= strobe.wrData & 8'h16; restartPulse <= 1'b1; end
          8'h04: begin rateQ <= strobe.wrData & 8'h77; restartPulse <= 1'b1; end
          8'h05: begin gainQ <= strobe.wrData & 8'h07; restartPulse <= 1'b1; end
          8'h19: icfgQ <= strobe.wrData & 8'h3C;
          8'h1A: persQ <= strobe.wrData & 8'hF0;
          8'h21: thrUpQ[7:0]        <= strobe.wrData;
          8'h22: thrUpQ[15:8]       <= strobe.wrData;
          8'h23: thrUpQ[RES_W-1:16] <= strobe.wrData[MSB_W-1:0];
          8'h24: thrLoQ[7:0]        <= strobe.wrData;
          8'h25: thrLoQ[15:8]       <= strobe.wrData;
          8'h26: thrLoQ[RES_W-1:16] <= strobe.wrData[MSB_W-1:0];
          8'h27: varQ <= strobe.wrData & 8'h07;
          default: ;
        endcase
      end
    end
  end

  // result shadow and visible copies, one set per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowQ[g] <= '0;
        visQ[g]    <= '0;
      end else begin
        if (commit)   visQ[g]    <= shadowQ[g];
        if (resValid) shadowQ[g] <= resFlat[g*RES_W +: RES_W];
      end
    end

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.lockRes |=> $stable(visQ[g])); // R11
  end

  // pending marker and status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= 1'b0;
      flagPow <= 1'b1;
      flagInt <= 1'b0;
      flagNew <= 1'b0;
    end else begin
      if (resValid)    pendQ <= 1'b1;
      else if (commit) pendQ <= 1'b0;
      if (rdStatus) flagPow <= 1'b0;
      if (intSet)        flagInt <= 1'b1;
      else if (rdStatus) flagInt <= 1'b0;
      if (commit)        flagNew <= 1'b1;
      else if (rdStatus) flagNew <= 1'b0;
    end
  end

  // read multiplexer
  always_comb begin
    readVal = 8'h00;
    case (strobe.rdAddr)
      8'h00: readVal = ctrlQ;
      8'h04: readVal = rateQ;
      8'h05: readVal = gainQ;
      8'h06: readVal = ID_VALUE;
      8'h07: readVal = {2'b00, flagPow, flagInt, flagNew, 3'b000};
      8'h19: readVal = icfgQ;
      8'h1A: readVal = persQ;
      8'h21: readVal = byteOf(thrUpQ, 0);
      8'h22: readVal = byteOf(thrUpQ, 1);
      8'h23: readVal = byteOf(thrUpQ, 2);
      8'h24: readVal = byteOf(thrLoQ, 0);
      8'h25: readVal = byteOf(thrLoQ, 1);
      8'h26: readVal = byteOf(thrLoQ, 2);
      8'h27: readVal = varQ;
      default: ;
    endcase
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int b = 0; b < 3; b++) begin
        if (strobe.rdAddr == DATA_BASE + 8'(3 * ch + b)) readVal = byteOf(visQ[ch], b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 8'h00;
    end else begin
      rdValid <= strobe.rdEn;
      rdData  <= strobe.rdBlank ? 8'h00 : readVal;
    end
  end

  AST_BLANK_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn && strobe.rdBlank |=> rdValid && rdData == 8'h00); // R7
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus |=> !flagPow); // R10

endmodule

// File: rtl/i2c_reg_engine.sv
module i2c_reg_engine
  import rae_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h52,
  parameter int         RES_W      = 20,
  parameter logic [7:0] ID_VALUE   = 8'hB2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bootDone,
  input  logic                startEv,
  input  logic [6:0]          addrIn,
  input  logic                dirRead,
  input  logic                rxValid,
  input  logic [7:0]          rxByte,
  input  logic                rdReq,
  input  logic                stopEv,
  input  logic                resValid,
  input  logic [4*RES_W-1:0]  resFlat,
  input  logic                intSet,
  output logic                ackValid,
  output logic                ackOut,
  output logic                rdValid,
  output logic [7:0]          rdData,
  output logic                restartPulse
);

  regStrobe_t strobe;

  rae_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .bootDone(bootDone), .startEv(startEv),
    .addrIn(addrIn), .dirRead(dirRead), .rxValid(rxValid), .rxByte(rxByte),
    .rdReq(rdReq), .stopEv(stopEv), .ackValid(ackValid), .ackOut(ackOut),
    .strobe(strobe)
  );

  rae_regs #(.RES_W(RES_W), .NUM_CH(4), .ID_VALUE(ID_VALUE)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resValid(resValid),
    .resFlat(resFlat), .intSet(intSet), .rdValid(rdValid), .rdData(rdData),
    .restartPulse(restartPulse)
  );

  AST_RESTART_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> ackValid && ackOut); // R12

endmodule

// File: tb/i2c_reg_engine_tb_top.sv
module i2c_reg_engine_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0, bootDone = 1'b0, startEv = 1'b0, dirRead = 1'b0;
  logic rxValid = 1'b0, rdReq = 1'b0, stopEv = 1'b0, resValid = 1'b0, intSet = 1'b0;
  logic [6:0]  addrIn = 7'h00;
  logic [7:0]  rxByte = 8'h00;
  logic [79:0] resFlat = '0;
  logic        ackValid, ackOut, rdValid, restartPulse;
  logic [7:0]  rdData;

  int errors = 0, checks = 0, restarts = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_reg_engine dut_i (
    .clk(clk), .rstN(rstN), .bootDone(bootDone), .startEv(startEv), .addrIn(addrIn),
    .dirRead(dirRead), .rxValid(rxValid), .rxByte(rxByte), .rdReq(rdReq),
    .stopEv(stopEv), .resValid(resValid), .resFlat(resFlat), .intSet(intSet),
    .ackValid(ackValid), .ackOut(ackOut), .rdValid(rdValid), .rdData(rdData),
    .restartPulse(restartPulse)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] mreg [256];
  int  mptr, mst, vis[4], sh[4];
  bit  mpe, pend, fPow, fInt, fNew;
  bit  eAckV, eAck, eRdV, eRst;
  logic [7:0] eRd;

  function automatic bit mValid(int a);
    return a == 0 || (a >= 4 && a <= 7) || (a >= 10 && a <= 21) || a == 25 || a == 26 ||
           (a >= 33 && a <= 39);
  endfunction
  function automatic bit mWr(int a);
    return a == 0 || a == 4 || a == 5 || a == 25 || a == 26 || (a >= 33 && a <= 39);
  endfunction
  function automatic logic [7:0] mMask(int a);
    case (a)
      0: return 8'h16;  4: return 8'h77;  5: return 8'h07;
      25: return 8'h3C; 26: return 8'hF0; 35, 38: return 8'h0F; 39: return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction
  function automatic int mNext(int a, bit wr);
    for (int i = a + 1; i <= 39; i++) if (wr ? mWr(i) : mValid(i)) return i;
    return -1;
  endfunction
  function automatic logic [7:0] mRead(int a);
    if (a == 7) return {2'b00, fPow, fInt, fNew, 3'b000};
    if (a >= 10 && a <= 21) return 8'((vis[(a - 10) / 3] >> (8 * ((a - 10) % 3))) & 255);
    return mreg[a];
  endfunction

  always @(posedge clk) begin
    bit lk, clr;
    int nx;
    if (!rstN) begin
      foreach (mreg[i]) mreg[i] = 8'h00;
      mreg[4] = 8'h22; mreg[5] = 8'h01; mreg[6] = 8'hB2; mreg[25] = 8'h10;
      mreg[33] = 8'hFF; mreg[34] = 8'hFF; mreg[35] = 8'h0F;
      mptr = 0; mst = 0; mpe = 0; pend = 0; fPow = 1; fInt = 0; fNew = 0;
      foreach (vis[i]) begin vis[i] = 0; sh[i] = 0; end
      eAckV = 0; eAck = 0; eRdV = 0; eRd = 0; eRst = 0;
    end else begin
      eAckV = 0; eRdV = 0; eRst = 0; eRd = 8'h00; clr = 0;
      lk = (mst == 3) && mptr >= 7 && mptr <= 24;
      if (startEv) begin
        eAckV = 1; mpe = 0;
        if (!bootDone || addrIn != 7'h52) begin eAck = 0; mst = 4; end
        else if (!dirRead) begin eAck = 1; mst = 1; end
        else if (mValid(mptr)) begin eAck = 1; mst = 3; end
        else begin eAck = 0; mst = 4; end
      end else if (stopEv) begin
        mst = 0; mpe = 0;
      end else begin
        if (rxValid) begin
          eAckV = 1; eAck = 0;
          if (mst == 1) begin mptr = rxByte; eAck = 1; mst = 2; end
          else if (mst == 2 && !mpe && mWr(mptr)) begin
            eAck = 1;
            mreg[mptr] = rxByte & mMask(mptr);
            if (mptr == 0 || mptr == 4 || mptr == 5) eRst = 1;
            nx = mNext(mptr, 1);
            if (nx < 0) mpe = 1; else mptr = nx;
          end else if (mst == 2) mpe = 1;
        end
        if (rdReq) begin
          eRdV = 1;
          if (mst == 3 && !mpe) begin
            eRd = mRead(mptr);
            if (mptr == 7) clr = 1;
            nx = mNext(mptr, 0);
            if (nx < 0) mpe = 1; else mptr = nx;
          end
        end
      end
      if (clr) begin fPow = 0; fInt = 0; fNew = 0; end
      if (intSet) fInt = 1;
      if (pend && !lk) begin
        foreach (vis[i]) vis[i] = sh[i];
        fNew = 1; pend = 0;
      end
      if (resValid) begin
        foreach (sh[i]) sh[i] = int'(resFlat[i*20 +: 20]);
        pend = 1;
      end
    end
  end

  // compare model against the design on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (eAckV || ackValid) begin
        checks++;
        if (ackValid !== eAckV || ackOut !== eAck) begin
          errors++;
          $display("FAIL R13 model ack: got v=%0b a=%0b exp v=%0b a=%0b", ackValid, ackOut, eAckV, eAck);
        end
      end
      if (eRdV || rdValid) begin
        checks++;
        if (rdValid !== eRdV || rdData !== eRd) begin
          errors++;
          $display("FAIL R7 model read: got v=%0b d=%02h exp v=%0b d=%02h", rdValid, rdData, eRdV, eRd);
        end
      end
      if (eRst || restartPulse) begin
        checks++;
        if (restartPulse !== eRst) begin
          errors++;
          $display("FAIL R12 model restart: got %0b exp %0b", restartPulse, eRst);
        end
      end
      if (restartPulse) restarts++;
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic doStart(input logic [6:0] a, input logic rd, output bit ack);
    @(negedge clk); startEv = 1; addrIn = a; dirRead = rd;
    @(negedge clk); startEv = 0; ack = ackOut;
  endtask
  task automatic sendB(input logic [7:0] b, output bit ack);
    @(negedge clk); rxValid = 1; rxByte = b;
    @(negedge clk); rxValid = 0; ack = ackOut;
  endtask
  task automatic readB(output logic [7:0] d);
    @(negedge clk); rdReq = 1;
    @(negedge clk); rdReq = 0; d = rdData;
  endtask
  task automatic doStop();
    @(negedge clk); stopEv = 1;
    @(negedge clk); stopEv = 0;
  endtask
  task automatic goRead(input logic [7:0] p);
    bit a;
    doStart(7'h52, 0, a);
    sendB(p, a);
    doStart(7'h52, 1, a);
  endtask
  task automatic expRead(input string tag, input int exp);
    logic [7:0] d;
    readB(d);
    check(tag, d, exp);
  endtask
  task automatic pushRes(input int ir, input int gr, input int bl, input int rd);
    @(negedge clk); resValid = 1;
    resFlat = {20'(rd), 20'(bl), 20'(gr), 20'(ir)};
    @(negedge clk); resValid = 0;
  endtask

  initial begin
    bit a;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9 restart idle", restartPulse, 0);
    check("R13 no ack after reset", ackValid, 0);

    doStart(7'h52, 0, a); check("R1 nack before boot", a, 0);
    doStop();
    bootDone = 1;
    doStart(7'h53, 0, a); check("R1 nack wrong address", a, 0);
    sendB(8'h00, a); check("R1 byte of foreign transfer", a, 0);
    doStop();

    doStart(7'h52, 0, a); check("R1 ack own address", a, 1);
    sendB(8'h00, a); check("R2 pointer byte ack", a, 1);
    doStart(7'h52, 1, a); check("R1 read address ack", a, 1);
    expRead("R9 control", 8'h00);
    expRead("R9 rate", 8'h22);
    expRead("R9 gain", 8'h01);
    expRead("R9 id", 8'hB2);
    expRead("R9 status", 8'h20);
    expRead("R7 skip to 0x0A", 8'h00);
    doStop();
    goRead(8'h07); expRead("R10 power flag cleared", 8'h00); doStop();
    goRead(8'h19); expRead("R9 int config", 8'h10); expRead("R9 persistence", 8'h00);
    expRead("R9 upper thr lsb", 8'hFF); doStop();

    doStart(7'h52, 0, a); sendB(8'h05, a);
    sendB(8'h02, a); check("R3 write gain", a, 1);
    sendB(8'hFF, a); check("R3 write lands 0x19", a, 1);
    sendB(8'h5A, a); check("R3 write lands 0x1A", a, 1);
    sendB(8'h11, a); check("R3 write lands 0x21", a, 1);
    doStop();
    check("R12 one restart", restarts, 1);
    goRead(8'h19);
    expRead("R3 0x19 masked", 8'h3C); expRead("R3 0x1A masked", 8'h50);
    expRead("R7 skip to 0x21", 8'h11); doStop();
    goRead(8'h05); expRead("R3 gain value", 8'h02); doStop();

    doStart(7'h52, 0, a); sendB(8'h27, a);
    sendB(8'hFD, a); check("R4 top write ack", a, 1);
    sendB(8'h33, a); check("R4 past end nack", a, 0);
    sendB(8'h44, a); check("R4 past end nack again", a, 0);
    doStop();
    goRead(8'h27);
    expRead("R6 variance masked", 8'h05);
    expRead("R7 past end zero", 8'h00);
    expRead("R7 past end zero again", 8'h00);
    doStop();
    goRead(8'h00); expRead("R4 no wrap to control", 8'h00); doStop();
    check("R12 no restart on 0x27", restarts, 1);

    doStart(7'h52, 0, a); sendB(8'h06, a); check("R5 pointer ack", a, 1);
    sendB(8'h00, a); check("R5 read-only nack", a, 0);
    sendB(8'h00, a); check("R5 nack held", a, 0);
    doStop();
    goRead(8'h06); expRead("R5 id unchanged", 8'hB2); doStop();

    doStart(7'h52, 0, a); sendB(8'h23, a); sendB(8'hFF, a); doStop();
    goRead(8'h23); expRead("R6 threshold msb", 8'h0F); doStop();
    check("R12 no restart on threshold", restarts, 1);
    doStart(7'h52, 0, a); sendB(8'h00, a); sendB(8'hFF, a); doStop();
    check("R12 restart on control", restarts, 2);
    goRead(8'h00); expRead("R6 control masked", 8'h16); doStop();

    doStart(7'h52, 0, a); sendB(8'h01, a);
    doStart(7'h52, 1, a); check("R8 reserved read nack", a, 0);
    expRead("R8 reserved read zero", 8'h00);
    doStop();

    pushRes('hABCDE, 'h00F0F, 'h80001, 'hFFFFF);
    repeat (3) @(negedge clk);
    goRead(8'h0A);
    expRead("R7 ir lsb", 8'hDE); expRead("R7 ir mid", 8'hBC); expRead("R6 ir msb", 8'h0A);
    expRead("R7 green lsb", 8'h0F); expRead("R7 green mid", 8'h0F); expRead("R6 green msb", 8'h00);
    expRead("R7 blue lsb", 8'h01); expRead("R7 blue mid", 8'h00); expRead("R6 blue msb", 8'h08);
    expRead("R7 red lsb", 8'hFF); expRead("R7 red mid", 8'hFF); expRead("R6 red msb", 8'h0F);
    doStop();
    goRead(8'h07); expRead("R10 new data flag", 8'h08); doStop();
    goRead(8'h07); expRead("R10 flags cleared", 8'h00); doStop();
    @(negedge clk); intSet = 1; @(negedge clk); intSet = 0;
    goRead(8'h07); expRead("R10 interrupt flag", 8'h10); doStop();

    goRead(8'h0A);
    expRead("R11 first byte", 8'hDE);
    pushRes('h12345, 'h00F0F, 'h80001, 'hFFFFF);
    repeat (3) @(negedge clk);
    expRead("R11 held mid", 8'hBC);
    expRead("R11 held msb", 8'h0A);
    doStop();
    repeat (2) @(negedge clk);
    goRead(8'h0A);
    expRead("R11 released lsb", 8'h45); expRead("R11 released mid", 8'h23);
    expRead("R11 released msb", 8'h01);
    doStop();

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule